// File: doc/BRIEF.md
# Interrupt Status, Host Interrupt Gate and ROM Bank Control

This block sits in the top 256 bytes of a storage controller's local register space, at offsets 0xF00 to 0xFFF. It lets driver software poll the raw interrupt request level of up to three IDE ports, each through its own 64-byte read window. It holds a one-way gate that decides whether those port interrupts reach the shared host interrupt line. The gate exists so that a faulty drive asserting its interrupt at power-up cannot stall system start.

The same address windows also act as write-only controls for the upper address bits of a banked boot ROM. A write can toggle a 16 KB swap bit, set bank bit 16 (which also closes the interrupt gate), or set bank bit 17 on builds that have a larger ROM. A write to the gate window opens the gate and clears every bank bit. The data value of a write is never used. Only the window that is hit matters.

Parameters choose the port count (two or three) and the ROM size class. The size class decides whether bank bit 17 exists and whether the swap bit drives ROM address 14 or ROM address 18.

Top module: `irq_bank_ctl`

## Requirements
- R1: After reset, rd_data is 0x00, host_irq is 0, and rom_a14, rom_a16, rom_a17 and rom_a18 are all 0. The interrupt gate is closed.
- R2: A read strobe with loc_addr in 0xF00–0xF3F, 0xF40–0xF7F or 0xF80–0xFBF loads rd_data on the next clock edge. Bit 7 holds the synchronized level of port 0, 1 or 2 respectively, and bits 6..0 are 0.
- R3: With NUM_PORTS=2, reads of the port 2 window return 0x00, and irq_raw[2] never causes host_irq.
- R4: A write anywhere in 0xFC0–0xFFF opens the interrupt gate. Reads in that window return 0x00 whatever the gate state, so the gate cannot be read back.
- R5: host_irq is 1 exactly when the gate is open and at least one synchronized port level is 1.
- R6: A write in 0xFC0–0xFFF clears the swap bit, bank bit 16 and bank bit 17.
- R7: A write in 0xF00–0xF3F toggles the swap bit. The swap bit drives rom_a14 when ROM_SEL is 0 or 1, and drives rom_a18 when ROM_SEL is 2; the other output stays 0.
- R8: A write in 0xF40–0xF7F sets rom_a16 and closes the interrupt gate.
- R9: With ROM_SEL of 1 or more, a write in 0xF80–0xFBF sets rom_a17. The bit then stays set through any other write until a write in 0xFC0–0xFFF.
- R10: Reads and writes with loc_addr outside 0xF00–0xFFF change no state, and a read there returns 0x00.
- R11: A change on irq_raw reaches host_irq after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_addr | input | 12 | Local byte offset of the access |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| irq_raw | input | 3 | Asynchronous IRQ lines of ports 0..2 |
| rd_data | output | 8 | Registered read data |
| host_irq | output | 1 | Gated interrupt to the host bus |
| rom_a14 | output | 1 | ROM address 14 (swap bit, small and medium ROM) |
| rom_a16 | output | 1 | ROM bank bit 16 |
| rom_a17 | output | 1 | ROM bank bit 17 |
| rom_a18 | output | 1 | ROM address 18 (swap bit, largest ROM) |

## Verification
The bench builds two copies that share every input. One copy has three ports and ROM_SEL=1, so the port 2 window, the bank 17 bit and swapping on address 14 can all be exercised. The other copy has two ports and ROM_SEL=2. That brings the silent port 2 window, the blocked third interrupt line and swapping on address 18 within reach under the same stimulus. A comparison of the two outputs in the same cycle shows each parameter's effect directly.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int LOC_W = 12;

    typedef enum logic [1:0] {
        WIN_P0   = 2'd0,
        WIN_P1   = 2'd1,
        WIN_P2   = 2'd2,
        WIN_GATE = 2'd3
    } win_e;

    typedef struct packed {
        logic hit;
        logic rd;
        logic wr;
        win_e win;
    } strobe_t;

    typedef struct packed {
        logic gate;
        logic swap;
        logic b16;
        logic b17;
    } bank_state_t;

endpackage

// File: rtl/irq_bank_sync.sv
module irq_bank_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);
    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = raw;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign lvl = stage_q[STAGES-1];
endmodule

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
(
    input  logic [LOC_W-1:0] loc_addr,
    input  logic             rd_stb,
    input  logic             wr_stb,
    output strobe_t          stb
);
    localparam int TOP_W = LOC_W - 8;

    logic [5:0] unused_low;
    assign unused_low = loc_addr[5:0];

    always_comb begin
        stb     = '0;
        stb.hit = (loc_addr[LOC_W-1:8] == {TOP_W{1'b1}});
        stb.win = win_e'(loc_addr[7:6]);
        stb.rd  = rd_stb & stb.hit;
        stb.wr  = wr_stb & stb.hit;
    end
endmodule

// File: rtl/irq_bank_state.sv
module irq_bank_state
    import irq_bank_pkg::*;
#(
    parameter int ROM_SEL = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  strobe_t     stb,
    output bank_state_t st_q
);
    localparam bit HAS_B17 = (ROM_SEL != 0);

    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (stb.wr) begin
            unique case (stb.win)
                WIN_P0:   st_d.swap = ~st_q.swap;
                WIN_P1: begin
                    st_d.b16  = 1'b1;
                    st_d.gate = 1'b0;
                end
                WIN_P2:   if (HAS_B17) st_d.b17 = 1'b1;
                WIN_GATE: begin
                    st_d.gate = 1'b1;
                    st_d.swap = 1'b0;
                    st_d.b16  = 1'b0;
                    st_d.b17  = 1'b0;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r4_gate_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr && stb.win == WIN_GATE) |=> st_q.gate);
    a_r6_bank_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr && stb.win == WIN_GATE) |=> (!st_q.swap && !st_q.b16 && !st_q.b17));
    a_r7_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr && stb.win == WIN_P0) |=> (st_q.swap != $past(st_q.swap)));
    a_r8_b16_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr && stb.win == WIN_P1) |=> (st_q.b16 && !st_q.gate));
    a_r9_b17_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.b17 && !(stb.wr && stb.win == WIN_GATE)) |=> st_q.b17);
    a_r10_no_change_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb.wr) |=> $stable(st_q));
endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl
    import irq_bank_pkg::*;
#(
    parameter int NUM_PORTS   = 3,
    parameter int ROM_SEL     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOC_W-1:0] loc_addr,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [2:0]       irq_raw,
    output logic [7:0]       rd_data,
    output logic             host_irq,
    output logic             rom_a14,
    output logic             rom_a16,
    output logic             rom_a17,
    output logic             rom_a18
);
    strobe_t         stb;
    bank_state_t     st_q;
    logic [2:0]      lvl;
    logic [NUM_PORTS-1:0] sync_lvl;

    typedef struct packed {
        logic [7:0] rdata;
    } out_t;
    out_t out_d, out_q;

    irq_bank_decode u_decode (
        .loc_addr (loc_addr),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .stb      (stb)
    );

    irq_bank_state #(.ROM_SEL(ROM_SEL)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .st_q  (st_q)
    );

    irq_bank_sync #(.N(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (irq_raw[NUM_PORTS-1:0]),
        .lvl   (sync_lvl)
    );

    generate
        if (NUM_PORTS == 2) begin : g_two_port
            logic unused_p2;
            assign unused_p2 = irq_raw[2];
            assign lvl = {1'b0, sync_lvl};
        end else begin : g_three_port
            assign lvl = sync_lvl;
        end
    endgenerate

    always_comb begin
        out_d = '0;
        if (stb.rd && stb.win != WIN_GATE) begin
            out_d.rdata = {lvl[stb.win], 7'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data  = out_q.rdata;
    assign host_irq = st_q.gate & (|lvl);
    assign rom_a16  = st_q.b16;
    assign rom_a17  = st_q.b17;

    generate
        if (ROM_SEL == 2) begin : g_swap_hi
            assign rom_a14 = 1'b0;
            assign rom_a18 = st_q.swap;
        end else begin : g_swap_lo
            assign rom_a14 = st_q.swap;
            assign rom_a18 = 1'b0;
        end
    endgenerate

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == 7'd0);
    a_r4_gate_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.rd && stb.win == WIN_GATE) |=> (rd_data == 8'h00));
    a_r10_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !stb.hit) |=> (rd_data == 8'h00));

    generate
        if (NUM_PORTS == 2) begin : g_chk_two
            a_r3_port2_silent: assert property (@(posedge clk) disable iff (!rst_n)
                (stb.rd && stb.win == WIN_P2) |=> (rd_data == 8'h00));
        end
    endgenerate
endmodule

// File: tb/irq_bank_ctl_bench.sv
module irq_bank_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] loc_addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [2:0]  irq_raw = '0;

    logic [7:0] rd_data, alt_rd_data;
    logic host_irq, rom_a14, rom_a16, rom_a17, rom_a18;
    logic alt_host_irq, alt_a14, alt_a16, alt_a17, alt_a18;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_bank_ctl #(.NUM_PORTS(3), .ROM_SEL(1)) u_irq_bank_ctl (
        .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .irq_raw(irq_raw), .rd_data(rd_data),
        .host_irq(host_irq), .rom_a14(rom_a14), .rom_a16(rom_a16),
        .rom_a17(rom_a17), .rom_a18(rom_a18));

    irq_bank_ctl #(.NUM_PORTS(2), .ROM_SEL(2)) u_irq_bank_ctl_alt (
        .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .irq_raw(irq_raw), .rd_data(alt_rd_data),
        .host_irq(alt_host_irq), .rom_a14(alt_a14), .rom_a16(alt_a16),
        .rom_a17(alt_a17), .rom_a18(alt_a18));

    // op[29:28] 0 idle 1 read 2 write | addr[27:16] | irq[15:13]
    // exp rd_data[12:5] | exp host_irq[4] | exp {a18,a17,a16,a14}[3:0]
    localparam int NV = 18;
    localparam logic [29:0] VEC [NV] = '{
        {2'd1, 12'hF00, 3'b001, 8'h80, 1'b0, 4'b0000}, // R2 port 0
        {2'd1, 12'hF3F, 3'b000, 8'h00, 1'b0, 4'b0000}, // R2 port 0 low
        {2'd1, 12'hF40, 3'b010, 8'h80, 1'b0, 4'b0000}, // R2 port 1
        {2'd1, 12'hF7C, 3'b101, 8'h00, 1'b0, 4'b0000}, // R2 port 1 low
        {2'd1, 12'hF80, 3'b100, 8'h80, 1'b0, 4'b0000}, // R2 port 2
        {2'd1, 12'hFBF, 3'b011, 8'h00, 1'b0, 4'b0000}, // R2 port 2 low
        {2'd1, 12'hFC0, 3'b111, 8'h00, 1'b0, 4'b0000}, // R5 gate closed
        {2'd2, 12'hFD3, 3'b111, 8'h00, 1'b1, 4'b0000}, // R4 gate opens
        {2'd2, 12'hF00, 3'b000, 8'h00, 1'b0, 4'b0001}, // R7 swap on
        {2'd2, 12'hF10, 3'b000, 8'h00, 1'b0, 4'b0000}, // R7 swap off
        {2'd2, 12'hF00, 3'b010, 8'h00, 1'b1, 4'b0001}, // R7 swap on
        {2'd2, 12'hF80, 3'b010, 8'h00, 1'b1, 4'b0101}, // R9 bank 17
        {2'd2, 12'hF40, 3'b010, 8'h00, 1'b0, 4'b0111}, // R8 bank 16
        {2'd2, 12'hF00, 3'b010, 8'h00, 1'b0, 4'b0110}, // R9 b17 held
        {2'd1, 12'hE00, 3'b111, 8'h00, 1'b0, 4'b0110}, // R10 read out
        {2'd2, 12'h700, 3'b111, 8'h00, 1'b0, 4'b0110}, // R10 write out
        {2'd2, 12'hFC0, 3'b001, 8'h00, 1'b1, 4'b0000}, // R6 clear all
        {2'd1, 12'hF41, 3'b000, 8'h00, 1'b0, 4'b0000}  // R5 no level
    };

    function automatic string req_of(input int i);
        case (i)
            0, 1, 2, 3, 4, 5: return "R2";
            6, 17:            return "R5";
            7:                return "R4";
            8, 9, 10:         return "R7";
            11, 13:           return "R9";
            12:               return "R8";
            14, 15:           return "R10";
            default:          return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [11:0] a);
        loc_addr = a;
        rd_stb   = (op == 2'd1);
        wr_stb   = (op == 2'd2);
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        wr_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", "rd_data", rd_data, 8'h00);
        check("R1", "host_irq", host_irq, 1'b0);
        check("R1", "rom bits", {rom_a18, rom_a17, rom_a16, rom_a14}, 4'b0000);
        check("R1", "alt rom bits", {alt_a18, alt_a17, alt_a16, alt_a14}, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            irq_raw = VEC[i][15:13];
            settle();
            run_op(VEC[i][29:28], VEC[i][27:16]);
            check(req_of(i), $sformatf("vec%0d rd_data", i), rd_data, VEC[i][12:5]);
            check(req_of(i), $sformatf("vec%0d host_irq", i), host_irq, VEC[i][4]);
            check(req_of(i), $sformatf("vec%0d rom", i),
                  {rom_a18, rom_a17, rom_a16, rom_a14}, VEC[i][3:0]);
        end

        // R1: reset closes the gate even with all lines high
        irq_raw = 3'b111;
        do_reset();
        settle();
        check("R1", "host after reset", host_irq, 1'b0);
        check("R1", "rom after reset", {rom_a18, rom_a17, rom_a16, rom_a14}, 4'b0000);

        // R3: two-port build hides port 2
        irq_raw = 3'b100;
        settle();
        run_op(2'd1, 12'hF80);
        check("R2", "main port 2 read", rd_data, 8'h80);
        check("R3", "alt port 2 read", alt_rd_data, 8'h00);
        run_op(2'd2, 12'hFC0);
        check("R5", "main host port 2", host_irq, 1'b1);
        check("R3", "alt host port 2", alt_host_irq, 1'b0);

        // R4: gate state cannot be read back
        irq_raw = 3'b111;
        settle();
        run_op(2'd1, 12'hFC0);
        check("R4", "gate read", rd_data, 8'h00);
        check("R4", "alt gate read", alt_rd_data, 8'h00);
        check("R5", "alt host port 0/1", alt_host_irq, 1'b1);

        // R11: two-edge latency
        irq_raw = 3'b000;
        settle();
        check("R11", "host idle", host_irq, 1'b0);
        irq_raw = 3'b001;
        @(posedge clk);
        @(negedge clk);
        check("R11", "host after one edge", host_irq, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R11", "host after two edges", host_irq, 1'b1);
        irq_raw = 3'b000;
        @(posedge clk);
        @(negedge clk);
        check("R11", "fall after one edge", host_irq, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R11", "fall after two edges", host_irq, 1'b0);

        // R7 / R9 on the largest ROM class
        run_op(2'd2, 12'hF00);
        check("R7", "alt swap on a18", {alt_a18, alt_a14}, 2'b10);
        check("R7", "main swap on a14", {rom_a18, rom_a14}, 2'b01);
        run_op(2'd2, 12'hF80);
        check("R9", "alt bank 17", alt_a17, 1'b1);
        run_op(2'd2, 12'hF40);
        check("R9", "alt bank 17 held", alt_a17, 1'b1);
        check("R8", "alt bank 16", alt_a16, 1'b1);
        run_op(2'd2, 12'hFC8);
        check("R6", "alt cleared", {alt_a18, alt_a17, alt_a16, alt_a14}, 4'b0000);
        check("R6", "main cleared", {rom_a18, rom_a17, rom_a16, rom_a14}, 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule